// File: doc/BRIEF.md
# Priority LED Status Multiplexer

This block decides the drive level of every board status LED from one place. Each LED walks its own short priority chain. A host-written bit in the remote GPIO word wins whenever the GPIO link reports itself active. Below that, an LED may show a shared blink pattern while board power is good and the reset button is held. At the bottom, a local status signal or a fixed level drives the LED.

One blink generator serves all LEDs. It divides the system clock down to a square wave of about 1.5 Hz, and its half period is derived from the clock frequency parameter. Every LED output comes from a flip-flop, so it changes only on a clock edge, one cycle after the inputs that select it. Pin mapping and the polarity of the LEDs on the board are handled outside this block.

Top module: `led_status_mux`

## Requirements
- R1: While `rst_n` is low at a clock edge, every LED output is driven low after that edge, and the blink wave restarts low with its divider cleared.
- R2: When `link_active_i` is high, LED channel k follows `host_gpio_i[6+k]` one cycle later. The channels are numbered: 0 green status, 1 red status, 2 to 5 SFP LEDs 0 to 3, 6 jack yellow, 7 jack green, 8 jack orange. This places them on bits 6 through 14.
- R3: With the link inactive, the green status LED shows the level of the active-low hub reset input `hub_rst_n_i`.
- R4: With the link inactive, the red status LED shows the level of the main reset from the companion controller, `main_rst_i`.
- R5: With the link inactive, each SFP LED shows the blink wave while `power_good_i` and `button_i` are both high. Otherwise it is low.
- R6: The blink wave starts low after reset and inverts after every HALF rising edges with `rst_n` high, where HALF = CLK_HZ*1000/(2*BLINK_MILLIHZ). The default of 1500 gives about 1.5 Hz. An LED showing the blink at edge n shows the wave value that held after n-1 edges.
- R7: The jack yellow LED, with the link inactive, uses this order. It blinks under the power-and-button condition. Failing that, it shows the inverse of `phy_led0_i` while `rst_strap_i` is low. Otherwise it is low.
- R8: The jack green LED, with the link inactive, uses this order. It blinks under the power-and-button condition. Failing that, it shows the inverse of `phy_led1_i` while `rst_strap_i` is low. Otherwise it is high.
- R9: The jack orange LED, with the link inactive, blinks under the power-and-button condition and is otherwise low.
- R10: The module LED shows the blink wave while `pwr_rst_i` is high and otherwise follows `module_pass_i`. The link has no influence on it.
- R11: Every output is registered. Its value after clock edge n depends only on the inputs sampled at edge n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_gpio_i | input | GPIO_W | Word written by the host over the GPIO link |
| link_active_i | input | 1 | GPIO link active; host bits take priority |
| power_good_i | input | 1 | Board power is good |
| button_i | input | 1 | Reset button held (active high) |
| hub_rst_n_i | input | 1 | Active-low USB hub reset state |
| main_rst_i | input | 1 | Main reset from the companion controller |
| rst_strap_i | input | 1 | Reset-strap line that gates the PHY activity fallback |
| phy_led0_i | input | 1 | PHY activity signal 0 |
| phy_led1_i | input | 1 | PHY activity signal 1 |
| pwr_rst_i | input | 1 | Main power reset in progress |
| module_pass_i | input | 1 | Host-driven pass-through level for the module LED |
| stat_green_o | output | 1 | Green status LED |
| stat_red_o | output | 1 | Red status LED |
| sfp_led_o | output | NUM_SFP | SFP LEDs |
| jack_yellow_o | output | 1 | Jack yellow LED |
| jack_green_o | output | 1 | Jack green LED |
| jack_orange_o | output | 1 | Jack orange LED |
| module_led_o | output | 1 | Module LED |

## Verification
The block could carry two kinds of wrong state: a divider count or wave phase out of step, or an LED register that latched the wrong source. A phase error shows at the ports as a blinking LED that toggles on the wrong edge. This becomes visible within one half period of holding the button condition, so the bench holds that condition across several half periods and predicts each toggle from its own edge count. A wrong priority or fallback shows on the next clock edge. The random stimulus covers every combination of link, power, button and strap across all channels, and each output is compared every cycle.

// File: rtl/led_mux_pkg.sv
// Package: shared types for the LED status multiplexer.
// Assumes channel numbering: 0 green status, 1 red status, 2..(1+NUM_SFP) SFP,
// then jack yellow, jack green, jack orange.
package led_mux_pkg;

    // Bottom-of-chain source for one LED channel.
    typedef enum logic [2:0] {
        FB_OFF       = 3'd0,
        FB_HUB_RST   = 3'd1,
        FB_MAIN_RST  = 3'd2,
        FB_PHY0_OFF  = 3'd3,
        FB_PHY1_ON   = 3'd4
    } fallback_e;

    typedef struct packed {
        logic      blink_en;   // middle level (blink under button) present
        fallback_e fb;         // lowest level
    } chan_cfg_t;

    // Per-channel configuration computed from the channel index.
    function automatic chan_cfg_t chan_cfg(input int idx, input int num_sfp);
        chan_cfg_t c;
        c.blink_en = 1'b0;
        c.fb       = FB_OFF;
        if (idx == 0) begin
            c.fb = FB_HUB_RST;
        end else if (idx == 1) begin
            c.fb = FB_MAIN_RST;
        end else if (idx < 2 + num_sfp) begin
            c.blink_en = 1'b1;
            c.fb       = FB_OFF;
        end else if (idx == 2 + num_sfp) begin
            c.blink_en = 1'b1;
            c.fb       = FB_PHY0_OFF;
        end else if (idx == 3 + num_sfp) begin
            c.blink_en = 1'b1;
            c.fb       = FB_PHY1_ON;
        end else begin
            c.blink_en = 1'b1;
            c.fb       = FB_OFF;
        end
        return c;
    endfunction

endpackage

// File: rtl/led_blink_gen.sv
// Module: led_blink_gen
// Divides the system clock into a slow square wave. The wave starts low after
// reset and inverts every HALF cycles. Assumes HALF >= 2.
module led_blink_gen #(
    parameter int unsigned CLK_HZ        = 100_000_000,
    parameter int unsigned BLINK_MILLIHZ = 1500
) (
    input  logic clk,
    input  logic rst_n,
    output logic wave_o
);
    localparam longint unsigned HALF_L =
        (longint'(CLK_HZ) * 64'd1000) / (64'd2 * longint'(BLINK_MILLIHZ));
    localparam int unsigned HALF  = int'(HALF_L);
    localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             wave_q;

    // Half-period counter and wave toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
        end else if (cnt_q == LAST) begin
            cnt_q  <= '0;
            wave_q <= ~wave_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign wave_o = wave_q;

    // Counter never leaves its range.
    assert_cnt_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
    // Wave holds unless the counter was at its last value.
    assert_wave_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != LAST) |=> $stable(wave_q));
    // Wave inverts when the counter wraps.
    assert_wave_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == LAST) |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/led_channel.sv
// Module: led_channel
// One LED with a three-level priority: host bit when the link is active, then
// the blink wave under the button condition (if enabled), then the fallback
// level supplied by the parent. The output is registered.
module led_channel #(
    parameter bit BLINK_EN = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_i,
    input  logic host_bit_i,
    input  logic blink_req_i,
    input  logic wave_i,
    input  logic fallback_i,
    output logic led_o
);
    logic next_led;
    logic led_q;

    // Priority selection of the next LED level.
    always_comb begin
        if (link_i)                      next_led = host_bit_i;
        else if (BLINK_EN && blink_req_i) next_led = wave_i;
        else                             next_led = fallback_i;
    end

    // Output register.
    always_ff @(posedge clk) begin
        if (!rst_n) led_q <= 1'b0;
        else        led_q <= next_led;
    end

    assign led_o = led_q;

    assert_host_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        link_i |=> (led_o == $past(host_bit_i)));
    assert_fallback_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_i && !(BLINK_EN && blink_req_i)) |=> (led_o == $past(fallback_i)));
    generate
        if (BLINK_EN) begin : g_blink_chk
            assert_blink_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!link_i && blink_req_i) |=> (led_o == $past(wave_i)));
        end
    endgenerate
endmodule

// File: rtl/led_status_mux.sv
// Module: led_status_mux (top)
// Drives all board status LEDs through per-channel priority chains that share
// one blink generator. Assumes GPIO_W >= HOST_BASE + NUM_CH and that all
// inputs are already synchronous to clk.
module led_status_mux #(
    parameter int unsigned CLK_HZ        = 100_000_000,
    parameter int unsigned BLINK_MILLIHZ = 1500,
    parameter int unsigned GPIO_W        = 32,
    parameter int unsigned NUM_SFP       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GPIO_W-1:0] host_gpio_i,
    input  logic              link_active_i,
    input  logic              power_good_i,
    input  logic              button_i,
    input  logic              hub_rst_n_i,
    input  logic              main_rst_i,
    input  logic              rst_strap_i,
    input  logic              phy_led0_i,
    input  logic              phy_led1_i,
    input  logic              pwr_rst_i,
    input  logic              module_pass_i,
    output logic              stat_green_o,
    output logic              stat_red_o,
    output logic [NUM_SFP-1:0] sfp_led_o,
    output logic              jack_yellow_o,
    output logic              jack_green_o,
    output logic              jack_orange_o,
    output logic              module_led_o
);
    import led_mux_pkg::*;

    localparam int unsigned HOST_BASE = 6;
    localparam int unsigned NUM_CH    = 5 + NUM_SFP;
    localparam int unsigned SFP_LO    = 2;
    localparam int unsigned JY_IDX    = 2 + NUM_SFP;
    localparam int unsigned JG_IDX    = 3 + NUM_SFP;
    localparam int unsigned JO_IDX    = 4 + NUM_SFP;

    logic              wave;
    logic              blink_req;
    logic [NUM_CH-1:0] led;
    logic              module_q;
    logic              unused_gpio;

    assign unused_gpio = ^{host_gpio_i[GPIO_W-1:HOST_BASE+NUM_CH], host_gpio_i[HOST_BASE-1:0]};

    // Shared blink condition: power good and button held.
    assign blink_req = power_good_i & button_i;

    led_blink_gen #(
        .CLK_HZ       (CLK_HZ),
        .BLINK_MILLIHZ(BLINK_MILLIHZ)
    ) blink_i (
        .clk   (clk),
        .rst_n (rst_n),
        .wave_o(wave)
    );

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            localparam chan_cfg_t CFG = chan_cfg(k, NUM_SFP);
            logic fb;

            // Lowest-priority level for this channel.
            always_comb begin
                case (CFG.fb)
                    FB_HUB_RST:  fb = hub_rst_n_i;
                    FB_MAIN_RST: fb = main_rst_i;
                    FB_PHY0_OFF: fb = rst_strap_i ? 1'b0 : ~phy_led0_i;
                    FB_PHY1_ON:  fb = rst_strap_i ? 1'b1 : ~phy_led1_i;
                    default:     fb = 1'b0;
                endcase
            end

            led_channel #(
                .BLINK_EN(CFG.blink_en)
            ) chan_i (
                .clk        (clk),
                .rst_n      (rst_n),
                .link_i     (link_active_i),
                .host_bit_i (host_gpio_i[HOST_BASE+k]),
                .blink_req_i(blink_req),
                .wave_i     (wave),
                .fallback_i (fb),
                .led_o      (led[k])
            );
        end
    endgenerate

    // Module LED: blink during main power reset, else pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n)         module_q <= 1'b0;
        else if (pwr_rst_i) module_q <= wave;
        else                module_q <= module_pass_i;
    end

    assign stat_green_o  = led[0];
    assign stat_red_o    = led[1];
    assign sfp_led_o     = led[SFP_LO +: NUM_SFP];
    assign jack_yellow_o = led[JY_IDX];
    assign jack_green_o  = led[JG_IDX];
    assign jack_orange_o = led[JO_IDX];
    assign module_led_o  = module_q;

    // All outputs low one edge after reset.
    assert_reset_low_R1: assert property (@(posedge clk)
        !rst_n |=> (led == '0 && !module_led_o));
    assert_green_fb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !link_active_i |=> (stat_green_o == $past(hub_rst_n_i)));
    assert_red_fb_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !link_active_i |=> (stat_red_o == $past(main_rst_i)));
    assert_sfp_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_active_i && !(power_good_i && button_i)) |=> (sfp_led_o == '0));
    assert_yellow_strap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_active_i && !(power_good_i && button_i) && rst_strap_i) |=> !jack_yellow_o);
    assert_jgreen_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_active_i && !(power_good_i && button_i) && rst_strap_i) |=> jack_green_o);
    assert_orange_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!link_active_i && !(power_good_i && button_i)) |=> !jack_orange_o);
    assert_module_pass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_rst_i |=> (module_led_o == $past(module_pass_i)));
endmodule

// File: tb/led_status_mux_tb_top.sv
module led_status_mux_tb_top;
    localparam int unsigned CLK_HZ  = 60;
    localparam int unsigned MHZ     = 1500;
    localparam int unsigned NUM_SFP = 4;
    localparam int          HALF    = (CLK_HZ * 1000) / (2 * MHZ); // R6

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] gpio = '0;
    logic link = 0, pg = 0, btn = 0, hub_n = 0, mrst = 0, strap = 0;
    logic phy0 = 0, phy1 = 0, prst = 0, mpass = 0;
    logic stat_g, stat_r, jy, jg, jo, modl;
    logic [NUM_SFP-1:0] sfp;

    int checks = 0;
    int fails  = 0;
    int edges  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    led_status_mux #(.CLK_HZ(CLK_HZ), .BLINK_MILLIHZ(MHZ), .GPIO_W(32), .NUM_SFP(NUM_SFP)) dut_i (
        .clk(clk), .rst_n(rst_n), .host_gpio_i(gpio), .link_active_i(link),
        .power_good_i(pg), .button_i(btn), .hub_rst_n_i(hub_n), .main_rst_i(mrst),
        .rst_strap_i(strap), .phy_led0_i(phy0), .phy_led1_i(phy1),
        .pwr_rst_i(prst), .module_pass_i(mpass),
        .stat_green_o(stat_g), .stat_red_o(stat_r), .sfp_led_o(sfp),
        .jack_yellow_o(jy), .jack_green_o(jg), .jack_orange_o(jo), .module_led_o(modl));

    // Edges since reset release (bench model of R6 timing).
    always @(posedge clk) begin
        if (!rst_n) edges <= 0;
        else        edges <= edges + 1;
    end

    function automatic logic wave_after(int k);
        if (k < 0) return 1'b0;
        return logic'((k / HALF) % 2);
    endfunction

    task automatic chk(string req, string nm, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %b expected %b at edge %0d", req, nm, act, exp, edges);
        end
    endtask

    // Compare all outputs with values predicted from the inputs held over the last edge.
    task automatic check_all();
        logic w, br, e;
        w  = wave_after(edges - 1);
        br = pg & btn;
        chk(link ? "R2" : "R3", "stat_green", stat_g, link ? gpio[6] : hub_n);
        chk(link ? "R2" : "R4", "stat_red",   stat_r, link ? gpio[7] : mrst);
        for (int i = 0; i < NUM_SFP; i++) begin
            e = link ? gpio[8+i] : (br ? w : 1'b0);
            chk(link ? "R2" : "R5", "sfp", sfp[i], e);
        end
        e = link ? gpio[12] : br ? w : (!strap ? ~phy0 : 1'b0);
        chk(link ? "R2" : "R7", "jack_yellow", jy, e);
        e = link ? gpio[13] : br ? w : (!strap ? ~phy1 : 1'b1);
        chk(link ? "R2" : "R8", "jack_green", jg, e);
        e = link ? gpio[14] : (br ? w : 1'b0);
        chk(link ? "R2" : "R9", "jack_orange", jo, e);
        chk("R10", "module", modl, prst ? w : mpass);
    endtask

    task automatic randomize_inputs(int bias);
        gpio  = $urandom();
        link  = ($urandom_range(0, 3) == 0);
        pg    = ($urandom_range(0, 3) != 0);
        btn   = ($urandom_range(0, 99) < bias);
        hub_n = $urandom_range(0, 1);
        mrst  = $urandom_range(0, 1);
        strap = $urandom_range(0, 1);
        phy0  = $urandom_range(0, 1);
        phy1  = $urandom_range(0, 1);
        prst  = $urandom_range(0, 1);
        mpass = $urandom_range(0, 1);
    endtask

    task automatic step_check();
        @(negedge clk);
        check_all();
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h1E5D_0C0A);
        // R1: reset state with inputs pushing outputs high
        gpio = '1; link = 1; prst = 0; mpass = 1; hub_n = 1; mrst = 1;
        repeat (3) @(negedge clk);
        chk("R1", "stat_green", stat_g, 1'b0);
        chk("R1", "stat_red", stat_r, 1'b0);
        chk("R1", "sfp0", sfp[0], 1'b0);
        chk("R1", "jack_green", jg, 1'b0);
        chk("R1", "module", modl, 1'b0);
        rst_n = 1'b1;
        // R11: one-cycle latency, host word visible after first edge
        step_check();
        // Directed R6/R5: hold blink condition across several half periods
        gpio = '0; link = 0; pg = 1; btn = 1; prst = 1; strap = 0;
        for (int i = 0; i < 5 * HALF; i++) step_check();
        // Directed R8: strap high, no button -> jack green on, yellow off
        btn = 0; strap = 1;
        step_check();
        chk("R8", "jack_green_on", jg, 1'b1);
        chk("R7", "jack_yellow_off", jy, 1'b0);
        // Directed R7/R8: strap low, PHY inverted
        strap = 0; phy0 = 0; phy1 = 1;
        step_check();
        chk("R7", "jack_yellow_phy", jy, 1'b1);
        chk("R8", "jack_green_phy", jg, 1'b0);
        // Directed R2: link active overrides blink condition
        link = 1; btn = 1; gpio = 32'h0000_5540;
        step_check();
        // Random mix
        for (int n = 0; n < 3000; n++) begin
            randomize_inputs((n / 500) % 2 == 0 ? 80 : 20);
            step_check();
        end
        // R1 again: mid-run reset restarts wave low
        rst_n = 0; link = 0; pg = 1; btn = 1;
        @(negedge clk);
        chk("R1", "sfp0_rst", sfp[0], 1'b0);
        rst_n = 1;
        for (int i = 0; i < 3 * HALF; i++) step_check();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog
    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule